// File: doc/BRIEF.md
# Low-Energy Serial Port Controller

This block is a word-addressed serial port for a register bus. Software sets the frame shape (parity and stop-bit count) and the bit time through control and divider registers. It writes bytes to a transmit data register, which feeds a one-byte holding stage ahead of a transmit shifter. It reads received bytes from a receive data register, which is the head of a four-entry receive FIFO. One level-sensitive interrupt line reports receive data and the transmit enables. The freeze and sync-busy registers are placeholders and always read zero.

A fractional accumulator makes a 16x oversampling tick. It advances by one unit of 256 every clock and fires when it reaches 256 plus the divider value. One bit therefore lasts 16*(1 + divider/256) clocks. The transmitter has the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. The transitions are:
- TX_IDLE to TX_START when the holding stage is full.
- TX_START to TX_DATA at the end of the bit.
- TX_DATA to TX_PAR or TX_STOP after the eighth bit, depending on parity.
- TX_PAR to TX_STOP at the end of the bit.
- TX_STOP to TX_IDLE after the last stop bit.

The receiver has the states RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP and RX_BREAK. The transitions are:
- RX_IDLE to RX_START on a low line.
- RX_START back to RX_IDLE if the line is high again at mid-start, otherwise to RX_DATA.
- RX_DATA to RX_PAR or RX_STOP after eight mid-bit samples.
- RX_PAR to RX_STOP at mid-bit.
- RX_STOP to RX_IDLE on a high stop bit, or to RX_BREAK on a low one.
- RX_BREAK to RX_IDLE once the line is high.

Top module: `lpu_uart`

## Requirements
- R1: After reset, status (offset 0x08) reads 0x10, interrupt flags (0x2C) read 0x03, `irq_o` is low and `txd_o` is high.
- R2: Offsets 0x40 and 0x44, and any offset that is not mapped, read as zero.
- R3: A write to clock control (0x0C) keeps only the bits under mask 0x7FF8, and the register reads back that masked value.
- R4: A transmitted frame is sent in this order: a low start bit, 8 data bits LSB first, an optional parity bit, then 1 or 2 high stop bits. Each bit lasts 16*(1+div/256) clocks, where div is the clock-control value.
- R5: Control bits [3:2] select parity: 00 gives none, 10 gives even, 11 gives odd, and the reserved value 01 behaves as none. Control bit 4 set gives two stop bits.
- R6: Flag bit 0 (TX complete) clears when a byte is accepted at 0x28. It sets when the last stop bit ends with nothing waiting in the holding stage. Status bit 4 and flag bit 1 show that the holding stage is empty. A write to 0x28 while the holding stage is full is dropped.
- R7: Each good received byte enters the FIFO and sets status bit 5 and flag bit 2. A read of 0x1C pops bytes in arrival order, status bit 5 clears when the FIFO empties, and a read of an empty FIFO returns 0.
- R8: Any write to 0x34 clears flag bit 2. Flag bits 3, 4 and 5 clear only where the written word has a 1.
- R9: `irq_o` = (enable bit 2 and FIFO not empty) or enable bit 1 or enable bit 0. The enable register is at 0x38.
- R10: The FIFO holds 4 bytes. A byte arriving when it is full is dropped and sets sticky flag bit 3.
- R11: A frame with a parity mismatch is not stored and sets flag bit 4.
- R12: A frame with a low stop bit is not stored and sets flag bit 5. The receiver accepts new frames once the line has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the baud reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line, idle high |
| irq_o | output | 1 | Level interrupt |

## Verification
The properties assume that every bus access is a single-cycle strobe with a stable address. A read of 0x1C is taken to pop exactly one byte on that same edge. They also assume that `rxd_i` is driven from one source whose bit boundaries fall at the configured bit time. The stimulus always returns the strobe low between accesses. It drives the receive line only at whole multiples of the bit time, which the bench derives from the divider it has written. It changes the control register only after TX complete shows that the transmitter is idle, so each frame's shape matches the mode that was in force when its byte was queued.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
    localparam int OVS = 16;

    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_STAT   = 'h08;
    localparam int OFS_CLKDIV = 'h0C;
    localparam int OFS_RXD    = 'h1C;
    localparam int OFS_TXD    = 'h28;
    localparam int OFS_IFLAG  = 'h2C;
    localparam int OFS_ICLR   = 'h34;
    localparam int OFS_IEN    = 'h38;
    localparam int OFS_FRZ    = 'h40;
    localparam int OFS_SYNC   = 'h44;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BREAK} rx_state_e;
endpackage

// File: rtl/lpu_baud.sv
module lpu_baud #(
    parameter int DIV_W = 12,
    parameter int LSB   = 3,
    parameter int FRAC  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int ACC_W = DIV_W + LSB + 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC;

    logic [ACC_W-1:0] acc_q, sum, step;

    assign step = {1'b0, div, {LSB{1'b0}}} + ONE;
    assign sum  = acc_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (sum >= step) begin
            acc_q <= sum - step;
            tick  <= 1'b1;
        end else begin
            acc_q <= sum;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/lpu_fifo.sv
module lpu_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= din;
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/lpu_tx.sv
module lpu_tx
    import lpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    output logic          txd,
    output logic          take,
    output logic          done,
    output logic          busy
);
    localparam int OS_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(DW);

    tx_state_e        st_q, st_d;
    logic [OS_W-1:0]  os_q;
    logic [BIT_W-1:0] idx_q;
    logic [DW-1:0]    sh_q;
    logic             pbit_q, pen_q, two_q, stop2_q;
    logic             bit_end, last_stop;

    assign bit_end   = tick && (os_q == OS_W'(OVS - 1));
    assign last_stop = !two_q || stop2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (load) st_d = TX_START;
            TX_START: if (bit_end) st_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == BIT_W'(DW - 1)) st_d = pen_q ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) st_d = TX_STOP;
            TX_STOP:  if (bit_end && last_stop) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0; idx_q <= '0; sh_q <= '0;
            pbit_q <= 1'b0; pen_q <= 1'b0; two_q <= 1'b0; stop2_q <= 1'b0;
        end else if (st_q == TX_IDLE) begin
            os_q <= '0; idx_q <= '0; stop2_q <= 1'b0;
            if (load) begin
                sh_q   <= data;
                pbit_q <= (^data) ^ par_odd;
                pen_q  <= par_en;
                two_q  <= two_stop;
            end
        end else begin
            if (tick) os_q <= os_q + 1'b1;
            if (bit_end && st_q == TX_DATA) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
            if (bit_end && st_q == TX_STOP) stop2_q <= 1'b1;
        end
    end

    always_comb begin
        txd  = 1'b1;
        take = 1'b0;
        done = 1'b0;
        busy = (st_q != TX_IDLE);
        unique case (st_q)
            TX_IDLE:  take = load;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_PAR:   txd = pbit_q;
            TX_STOP:  done = bit_end && last_stop;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/lpu_rx.sv
module lpu_rx
    import lpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          push,
    output logic [DW-1:0] data,
    output logic          par_err,
    output logic          frm_err
);
    localparam int OS_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(DW);

    rx_state_e        st_q, st_d;
    logic [OS_W-1:0]  os_q;
    logic [BIT_W-1:0] idx_q;
    logic [DW-1:0]    sh_q;
    logic             pbit_q, mid, half, mismatch;

    assign mid      = tick && (os_q == OS_W'(OVS - 1));
    assign half     = tick && (os_q == OS_W'(OVS / 2 - 1));
    assign mismatch = par_en && (pbit_q != ((^sh_q) ^ par_odd));
    assign data     = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (!rxd) st_d = RX_START;
            RX_START: if (half) st_d = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (mid && idx_q == BIT_W'(DW - 1)) st_d = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (mid) st_d = RX_STOP;
            RX_STOP:  if (mid) st_d = rxd ? RX_IDLE : RX_BREAK;
            RX_BREAK: if (rxd) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0; idx_q <= '0; sh_q <= '0; pbit_q <= 1'b0;
        end else begin
            case (st_q)
                RX_IDLE: begin
                    os_q  <= '0;
                    idx_q <= '0;
                end
                RX_START: if (tick) os_q <= half ? '0 : os_q + 1'b1;
                RX_DATA: begin
                    if (tick) os_q <= os_q + 1'b1;
                    if (mid) begin
                        sh_q  <= {rxd, sh_q[DW-1:1]};
                        idx_q <= idx_q + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (tick) os_q <= os_q + 1'b1;
                    if (mid) pbit_q <= rxd;
                end
                RX_STOP: if (tick) os_q <= os_q + 1'b1;
                default: os_q <= '0;
            endcase
        end
    end

    always_comb begin
        push    = 1'b0;
        par_err = 1'b0;
        frm_err = 1'b0;
        unique case (st_q)
            RX_STOP: begin
                push    = mid && rxd && !mismatch;
                par_err = mid && rxd && mismatch;
                frm_err = mid && !rxd;
            end
            default: push = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpu_uart.sv
module lpu_uart
    import lpu_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic              irq_o
);
    localparam int DIV_LSB = 3;
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

    logic [2:0]       ctrl_q;
    logic [DIV_W-1:0] clkdiv_q;
    logic [2:0]       ien_q;
    logic             txc_q, rxf_q, ovf_q, perr_q, ferr_q;
    logic             hold_v, rxd_m, rxd_s;
    logic [7:0]       hold_d, rx_data, fifo_dout;
    logic             tick, take, tx_done, tx_busy;
    logic             rx_push, rx_perr, rx_ferr;
    logic             rx_empty, rx_full, rx_pop;
    logic [CNT_W-1:0] fifo_cnt;
    logic             wr, rd;

    assign wr     = bus_sel && bus_wr;
    assign rd     = bus_sel && !bus_wr;
    assign rx_pop = rd && (bus_addr == ADDR_W'(OFS_RXD));

    lpu_baud #(.DIV_W(DIV_W), .LSB(DIV_LSB), .FRAC(8)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(clkdiv_q), .tick(tick));

    lpu_tx #(.DW(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(hold_v), .data(hold_d),
        .par_en(ctrl_q[1]), .par_odd(ctrl_q[1] & ctrl_q[0]), .two_stop(ctrl_q[2]),
        .txd(txd_o), .take(take), .done(tx_done), .busy(tx_busy));

    lpu_rx #(.DW(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s),
        .par_en(ctrl_q[1]), .par_odd(ctrl_q[1] & ctrl_q[0]),
        .push(rx_push), .data(rx_data), .par_err(rx_perr), .frm_err(rx_ferr));

    lpu_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data), .pop(rx_pop),
        .dout(fifo_dout), .empty(rx_empty), .full(rx_full), .count(fifo_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd_i;
            rxd_s <= rxd_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; clkdiv_q <= '0; ien_q <= '0;
            hold_v <= 1'b0; hold_d <= '0;
            txc_q <= 1'b1; rxf_q <= 1'b0; ovf_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
        end else begin
            if (take) hold_v <= 1'b0;
            if (tx_done && !hold_v) txc_q <= 1'b1;
            if (wr) begin
                case (bus_addr)
                    ADDR_W'(OFS_CTRL):   ctrl_q   <= bus_wdata[4:2];
                    ADDR_W'(OFS_CLKDIV): clkdiv_q <= bus_wdata[DIV_W+DIV_LSB-1:DIV_LSB];
                    ADDR_W'(OFS_IEN):    ien_q    <= bus_wdata[2:0];
                    ADDR_W'(OFS_TXD): if (!hold_v) begin
                        hold_v <= 1'b1;
                        hold_d <= bus_wdata[7:0];
                        txc_q  <= 1'b0;
                    end
                    ADDR_W'(OFS_ICLR): begin
                        rxf_q <= 1'b0;
                        if (bus_wdata[3]) ovf_q  <= 1'b0;
                        if (bus_wdata[4]) perr_q <= 1'b0;
                        if (bus_wdata[5]) ferr_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (rx_push && !rx_full) rxf_q  <= 1'b1;
            if (rx_push && rx_full)  ovf_q  <= 1'b1;
            if (rx_perr)             perr_q <= 1'b1;
            if (rx_ferr)             ferr_q <= 1'b1;
        end
    end

    assign irq_o = (ien_q[2] && !rx_empty) || ien_q[1] || ien_q[0];

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                ADDR_W'(OFS_CTRL):   bus_rdata = {27'd0, ctrl_q, 2'b00};
                ADDR_W'(OFS_STAT):   bus_rdata = {26'd0, !rx_empty, !hold_v, 4'd0};
                ADDR_W'(OFS_CLKDIV): bus_rdata = 32'({clkdiv_q, {DIV_LSB{1'b0}}});
                ADDR_W'(OFS_RXD):    bus_rdata = rx_empty ? 32'd0 : {24'd0, fifo_dout};
                ADDR_W'(OFS_IFLAG):  bus_rdata = {26'd0, ferr_q, perr_q, ovf_q, rxf_q, !hold_v, txc_q};
                ADDR_W'(OFS_IEN):    bus_rdata = {29'd0, ien_q};
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lpu_uart_chk.sv
module lpu_uart_chk
    import lpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 4,
    parameter int DIV_W  = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic [31:0]                 bus_rdata,
    input logic                        txd_o,
    input logic                        irq_o,
    input logic                        tx_busy,
    input logic                        rx_empty,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_cnt,
    input logic [DIV_W-1:0]            clkdiv_q,
    input logic [2:0]                  ien_q
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [DIV_W+2:0] DIV_MASK = {{DIV_W{1'b1}}, 3'b000};

    a_r2_zero_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_FRZ) || bus_addr == ADDR_W'(OFS_SYNC)))
        |-> bus_rdata == 32'd0);

    a_r3_div_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_CLKDIV))
        |=> ({clkdiv_q, 3'b000} == ($past(bus_wdata[DIV_W+2:0]) & DIV_MASK)));

    a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd_o);

    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_RXD) && rx_empty) |-> bus_rdata == 32'd0);

    a_r9_tx_enable_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[0] || ien_q[1]) |-> irq_o);

    a_r9_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 3'b000) |-> !irq_o);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));
endmodule

bind lpu_uart lpu_uart_chk #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd_o(txd_o), .irq_o(irq_o),
    .tx_busy(tx_busy), .rx_empty(rx_empty), .fifo_cnt(fifo_cnt),
    .clkdiv_q(clkdiv_q), .ien_q(ien_q));

// File: tb/lpu_uart_tb_top.sv
module lpu_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd_i = 1'b1;
    logic        txd_o, irq_o;

    int n_chk = 0, n_fail = 0;
    int bit_clks = 16;
    logic [4:0] cur_ctrl = '0;
    logic [10:0] txq[$];
    logic [7:0]  rxq[$];
    bit finished = 0;

    always #2.5 clk = ~clk;

    lpu_uart dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd_i(rxd_i), .txd_o(txd_o), .irq_o(irq_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic [1:0] mode);
        return (mode == 2'b11) ? ~(^d) : (^d);
    endfunction

    // driver: queue the expected frame, then write the byte
    task automatic tx_byte(input logic [7:0] d);
        logic pen;
        pen = (cur_ctrl[3:2] == 2'b10) || (cur_ctrl[3:2] == 2'b11);
        txq.push_back({cur_ctrl[4], pen, par_of(d, cur_ctrl[3:2]), d});
        bus_write(8'h28, {24'd0, d});
    endtask

    task automatic wait_tx_idle();
        logic [31:0] f, s;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h2C, f);
            bus_read(8'h08, s);
            if (f[0] && s[4]) break;
        end
        repeat (2 * bit_clks) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] d, input logic [1:0] mode,
                           input bit bad_par, input bit bad_stop, input bit keep);
        logic pen;
        pen = mode[1];
        if (keep) rxq.push_back(d);
        rxd_i = 1'b0; repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_i = d[i]; repeat (bit_clks) @(negedge clk);
        end
        if (pen) begin
            rxd_i = par_of(d, mode) ^ bad_par; repeat (bit_clks) @(negedge clk);
        end
        rxd_i = !bad_stop; repeat (bit_clks) @(negedge clk);
        rxd_i = 1'b1; repeat (2 * bit_clks) @(negedge clk);
    endtask

    // monitor: decode frames on txd_o and compare against the queue (R4, R5)
    initial begin
        forever begin
            logic [7:0] got;
            logic [10:0] e;
            logic pb, s1, s2, st;
            @(negedge txd_o);
            repeat (bit_clks / 2) @(negedge clk);
            st = txd_o;
            for (int i = 0; i < 8; i++) begin
                repeat (bit_clks) @(negedge clk);
                got[i] = txd_o;
            end
            e = (txq.size() > 0) ? txq.pop_front() : 11'h7FF;
            pb = 1'b0;
            if (e[9]) begin
                repeat (bit_clks) @(negedge clk);
                pb = txd_o;
            end
            repeat (bit_clks) @(negedge clk);
            s1 = txd_o;
            s2 = 1'b1;
            if (e[10]) begin
                repeat (bit_clks) @(negedge clk);
                s2 = txd_o;
            end
            chk("R4 start bit", {31'd0, st}, 32'd0);
            chk("R4 data LSB first", {24'd0, got}, {24'd0, e[7:0]});
            chk("R5 parity bit", {31'd0, pb}, {31'd0, e[9] ? e[8] : 1'b0});
            chk("R5 stop bits", {30'd0, s1, s2}, 32'd3);
        end
    end

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(8'h08, v); chk("R1 status", v, 32'h10);
        bus_read(8'h2C, v); chk("R1 flags", v, 32'h03);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 txd idle", {31'd0, txd_o}, 32'd1);
        // R2 zero registers
        bus_read(8'h40, v); chk("R2 freeze", v, 0);
        bus_read(8'h44, v); chk("R2 sync-busy", v, 0);
        bus_read(8'h10, v); chk("R2 unmapped", v, 0);
        bus_read(8'h1C, v); chk("R7 empty read", v, 0);
        // R3 divider mask
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, v); chk("R3 divider mask", v, 32'h7FF8);
        bus_write(8'h0C, 32'h0);

        // R4/R6: bit time 16 clocks at div 0, TX complete clears then sets
        tx_byte(8'h00);
        bus_read(8'h2C, v); chk("R6 TX complete cleared", {31'd0, v[0]}, 0);
        while (txd_o) @(negedge clk);
        n = 0;
        while (!txd_o) begin n++; @(negedge clk); end
        chk("R4 nine low bits = 144 clocks", {31'd0, (n >= 143 && n <= 145)}, 1);
        wait_tx_idle();
        bus_read(8'h2C, v); chk("R6 TX complete set", {31'd0, v[0]}, 1);
        bus_read(8'h08, v); chk("R6 holding empty", {31'd0, v[4]}, 1);

        // R5 parity modes and stop count
        cur_ctrl = 5'h08; bus_write(8'h00, {27'd0, cur_ctrl});
        tx_byte(8'hA5); tx_byte(8'h3C);
        bus_read(8'h08, v); chk("R6 holding full after second write", {31'd0, v[4]}, 0);
        wait_tx_idle();
        cur_ctrl = 5'h0C; bus_write(8'h00, {27'd0, cur_ctrl});
        tx_byte(8'h81); wait_tx_idle();
        cur_ctrl = 5'h10; bus_write(8'h00, {27'd0, cur_ctrl});
        tx_byte(8'h55); wait_tx_idle();
        cur_ctrl = 5'h04; bus_write(8'h00, {27'd0, cur_ctrl});   // reserved: no parity
        tx_byte(8'hF0); wait_tx_idle();
        // R4 fractional divider: 0x80 -> 24 clocks per bit
        cur_ctrl = 5'h00; bus_write(8'h00, 0);
        bus_write(8'h0C, 32'h80); bit_clks = 24;
        tx_byte(8'h3A); wait_tx_idle();
        bus_write(8'h0C, 0); bit_clks = 16;
        repeat (40) @(negedge clk);
        chk("R4 all frames seen", txq.size(), 0);

        // R7 receive path, even parity
        cur_ctrl = 5'h08; bus_write(8'h00, {27'd0, cur_ctrl});
        rx_send(8'h11, 2'b10, 0, 0, 1);
        rx_send(8'h22, 2'b10, 0, 0, 1);
        rx_send(8'h33, 2'b10, 0, 0, 1);
        bus_read(8'h08, v); chk("R7 status rx bit", {31'd0, v[5]}, 1);
        bus_read(8'h2C, v); chk("R7 rx flag", {31'd0, v[2]}, 1);
        chk("R9 irq off with no enables", {31'd0, irq_o}, 0);
        bus_write(8'h38, 32'h4);
        #1 chk("R9 irq from rx enable", {31'd0, irq_o}, 1);
        for (int i = 0; i < 3; i++) begin
            bus_read(8'h1C, v);
            chk("R7 pop order", v, {24'd0, rxq.pop_front()});
        end
        bus_read(8'h08, v); chk("R7 status clears when empty", {31'd0, v[5]}, 0);
        chk("R9 irq drops when empty", {31'd0, irq_o}, 0);
        bus_write(8'h34, 32'h0);
        bus_read(8'h2C, v); chk("R8 clear rx flag", {31'd0, v[2]}, 0);
        bus_write(8'h38, 32'h1);
        #1 chk("R9 irq from tx-complete enable", {31'd0, irq_o}, 1);
        bus_write(8'h38, 32'h0);

        // R10 overflow
        for (int i = 0; i < 5; i++) rx_send(8'h40 + 8'(i), 2'b10, 0, 0, i < 4);
        bus_read(8'h2C, v); chk("R10 overflow flag", {31'd0, v[3]}, 1);
        for (int i = 0; i < 4; i++) begin
            bus_read(8'h1C, v);
            chk("R10 first four kept", v, {24'd0, rxq.pop_front()});
        end
        bus_read(8'h1C, v); chk("R10 fifth dropped", v, 0);
        bus_write(8'h34, 32'h0);
        bus_read(8'h2C, v); chk("R8 overflow sticky without bit", {31'd0, v[3]}, 1);
        bus_write(8'h34, 32'h8);
        bus_read(8'h2C, v); chk("R8 overflow cleared by bit 3", {31'd0, v[3]}, 0);

        // R11 parity mismatch
        rx_send(8'h6B, 2'b10, 1, 0, 0);
        bus_read(8'h08, v); chk("R11 nothing stored", {31'd0, v[5]}, 0);
        bus_read(8'h2C, v); chk("R11 parity flag", {31'd0, v[4]}, 1);
        bus_write(8'h34, 32'h10);

        // R12 framing error, then recovery
        rx_send(8'h77, 2'b10, 0, 1, 0);
        bus_read(8'h08, v); chk("R12 nothing stored", {31'd0, v[5]}, 0);
        bus_read(8'h2C, v); chk("R12 framing flag", {31'd0, v[5]}, 1);
        rx_send(8'h9C, 2'b10, 0, 0, 1);
        bus_read(8'h1C, v); chk("R12 recovers after break", v, {24'd0, rxq.pop_front()});

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule